// File: doc/BRIEF.md
# Taken-Branch Target Predictor

This block remembers branches that were taken and, running ahead of instruction decode, finds them again so that fetch can start on the predicted target early. The storage is two-way set associative. Each way of each set holds a branch tag, the low bits of its target, a code-class bit and a two-bit confidence state. A search is started with an address and a code class. The block then walks forward one 16-byte chunk per cycle. It stops at the first chunk that holds a matching branch, or at the last chunk of the 256-byte line that follows the starting line. In either case it emits a one-cycle result. Branch resolution feeds an update port with the outcome and the correct target. The update port installs, strengthens, weakens, evicts or retargets entries.

The sequencer has two states. FS_IDLE waits for a start. FS_SCAN looks up one chunk per cycle. Transitions: a start moves to FS_SCAN from either state, and a start during a scan restarts it. FS_SCAN returns to FS_IDLE on a hit or after the last chunk of the window. Otherwise FS_SCAN stays in FS_SCAN and advances one chunk. Entry states are BS_EMPTY (00), BS_WEAK (01), BS_STRONG (10) and BS_MOVING (11). BS_MOVING marks a branch whose target changes, so fetch must not use it. A global enable, a recovery clear and per-way disable bits support error handling.

Top module: `btb_predictor`

## Requirements
- R1: Entries are located by set index addr[13:4] and tag addr[26:14], one branch per 16-byte chunk per way. A resolved-taken branch that is not present is installed as BS_STRONG, and a later search reports a hit with res_br_addr equal to its chunk address (low 4 bits zero). A not-taken branch that is not present is never installed.
- R2: The predicted target is bits [31:19] of the hit chunk address followed by the 19 stored target bits.
- R3: When an entry resolves not taken, BS_STRONG becomes BS_WEAK and BS_WEAK becomes BS_EMPTY, which is a miss. When it resolves taken with the stored target, both BS_WEAK and BS_MOVING become BS_STRONG.
- R4: When an entry resolves taken with a different target, the target is rewritten and the entry becomes BS_MOVING. A hit on a BS_MOVING entry sets res_chg. A BS_MOVING entry that resolves not taken becomes BS_WEAK.
- R5: The code-class bit (0 normal, 1 internal) is latched at search start. A hit requires the stored class to equal it. The same address may be held once in each class.
- R6: Each set has one replacement bit that names the way to be replaced next. After a hit or an install it names the other way. An install goes to an enabled empty way (way 0 first), otherwise to the way the bit names. Resolving a present branch never creates a second copy.
- R7: A start sampled on edge N makes busy high. The chunk holding the start address is looked up at edge N+1, and each later edge looks up the next chunk. res_valid is high for one cycle after the deciding edge. The window ends at the last chunk of the line after the start line. The first hit in address order is reported.
- R8: A start while busy abandons the current scan and begins a new one.
- R9: While en is low, lookups miss and the update port has no effect.
- R10: When an accepted update targets the same set as the chunk being looked up in that cycle, the update is applied and that chunk's lookup misses.
- R11: A cycle with rcv_clear high empties every entry, ignores the update port and makes that cycle's lookup miss.
- R12: A way whose way_off bit is set neither hits, nor matches for resolution, nor receives installs.
- R13: After reset, busy and res_valid are low and every entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable for lookups and updates |
| rcv_clear | input | 1 | Recovery clear of all entries |
| way_off | input | 2 | Per-way exclusion, bit w removes way w |
| srch_start | input | 1 | Start a search |
| srch_addr | input | 32 | Search start address |
| srch_mode | input | 1 | Code class of the search |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | One-cycle search result strobe |
| res_hit | output | 1 | Result found a branch |
| res_target | output | 32 | Predicted target |
| res_chg | output | 1 | Hit entry has a changing target |
| res_br_addr | output | 32 | Chunk address of the hit branch |
| upd_valid | input | 1 | Resolution update strobe |
| upd_addr | input | 32 | Resolved branch address |
| upd_mode | input | 1 | Code class of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Correct target |

## Verification
The bench targets the edges of the confidence ladder. A design that evicted on the first not-taken, or never left BS_MOVING, would report the wrong hit, miss or res_chg flag after a short series of outcomes. It also checks the scan window against a branch in the last chunk of the following line, a branch two lines ahead and a branch behind the start. An off-by-one bound, or a walk that restarts from the line base, reports the wrong branch. An update placed in the exact lookup cycle of the same set catches a design that lets the stale lookup hit. Way exclusion and replacement order are checked by which of three branches in one set still hit.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int BTB_WAYS = 2;

    typedef enum logic [1:0] {
        BS_EMPTY  = 2'b00,
        BS_WEAK   = 2'b01,
        BS_STRONG = 2'b10,
        BS_MOVING = 2'b11
    } bst_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_SCAN = 1'b1
    } fsm_e;
endpackage

// File: rtl/btb_way_match.sv
module btb_way_match #(
    parameter int TAG_W = 13
) (
    input  logic [btb_pkg::BTB_WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [btb_pkg::BTB_WAYS-1:0][1:0]       set_states,
    input  logic [btb_pkg::BTB_WAYS-1:0]            set_modes,
    input  logic [btb_pkg::BTB_WAYS-1:0]            way_off,
    input  logic [TAG_W-1:0]                        want_tag,
    input  logic                                    want_mode,
    output logic [btb_pkg::BTB_WAYS-1:0]            occupied,
    output logic                                    any,
    output logic                                    way
);
    logic [btb_pkg::BTB_WAYS-1:0] match;

    for (genvar w = 0; w < btb_pkg::BTB_WAYS; w++) begin : g_way
        assign occupied[w] = (set_states[w] != 2'b00);
        assign match[w]    = occupied[w] && !way_off[w]
                             && (set_tags[w] == want_tag)
                             && (set_modes[w] == want_mode);
    end

    assign any = |match;
    assign way = !match[0];
endmodule

// File: rtl/btb_victim.sv
module btb_victim (
    input  logic [1:0] occupied,
    input  logic [1:0] way_off,
    input  logic       lru,
    output logic       ok,
    output logic       victim
);
    always_comb begin
        ok = !(&way_off);
        if (way_off[0])       victim = 1'b1;
        else if (way_off[1])  victim = 1'b0;
        else if (!occupied[0]) victim = 1'b0;
        else if (!occupied[1]) victim = 1'b1;
        else                  victim = lru;
    end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
(
    input  logic found,
    input  bst_e cur,
    input  logic taken,
    input  logic tgt_same,
    output logic modify,
    output bst_e nxt,
    output logic load_tgt,
    output logic want_install
);
    always_comb begin
        modify       = found;
        want_install = !found && taken;
        load_tgt     = found && taken && !tgt_same;
        nxt          = cur;
        if (taken) begin
            nxt = tgt_same ? BS_STRONG : BS_MOVING;
        end else begin
            unique case (cur)
                BS_STRONG: nxt = BS_WEAK;
                BS_WEAK:   nxt = BS_EMPTY;
                BS_MOVING: nxt = BS_WEAK;
                BS_EMPTY:  nxt = BS_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 13,
    parameter int TGT_W  = 19,
    parameter int OFF_W  = 4,
    parameter int LINE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rcv_clear,
    input  logic [1:0]    way_off,
    input  logic          srch_start,
    input  logic [AW-1:0] srch_addr,
    input  logic          srch_mode,
    output logic          busy,
    output logic          res_valid,
    output logic          res_hit,
    output logic [AW-1:0] res_target,
    output logic          res_chg,
    output logic [AW-1:0] res_br_addr,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_addr,
    input  logic          upd_mode,
    input  logic          upd_taken,
    input  logic [AW-1:0] upd_target
);
    localparam int SETS    = 1 << IDX_W;
    localparam int CW      = AW - OFF_W;
    localparam int LINE_CH = LINE_W - OFF_W;
    localparam int WAYS    = BTB_WAYS;

    // entry storage, one array per field
    logic [TAG_W-1:0] tag_q  [WAYS][SETS];
    logic [TGT_W-1:0] tgt_q  [WAYS][SETS];
    logic             mode_q [WAYS][SETS];
    bst_e             st_q   [WAYS][SETS];
    logic             lru_q  [SETS];

    // sequencer state
    fsm_e          state_q, state_d;
    logic [CW-1:0] chunk_q, chunk_d, last_q, last_d;
    logic          smode_q, smode_d;

    logic [CW-1:0]    start_chunk;
    logic [CW-1:0]    u_chunk;
    logic [IDX_W-1:0] s_idx, u_idx;
    logic [TAG_W-1:0] s_tag, u_tag;

    assign start_chunk = srch_addr[AW-1:OFF_W];
    assign u_chunk     = upd_addr[AW-1:OFF_W];
    assign s_idx       = chunk_q[IDX_W-1:0];
    assign s_tag       = chunk_q[IDX_W +: TAG_W];
    assign u_idx       = u_chunk[IDX_W-1:0];
    assign u_tag       = u_chunk[IDX_W +: TAG_W];

    logic unused_bits;
    assign unused_bits = ^{upd_addr[OFF_W-1:0], upd_target[AW-1:TGT_W],
                           u_chunk[CW-1:IDX_W+TAG_W], srch_addr[OFF_W-1:0]};

    // read the addressed sets
    logic [WAYS-1:0][TAG_W-1:0] s_tags, u_tags;
    logic [WAYS-1:0][1:0]       s_sts, u_sts;
    logic [WAYS-1:0]            s_modes, u_modes;

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign s_tags[w]  = tag_q[w][s_idx];
        assign s_sts[w]   = st_q[w][s_idx];
        assign s_modes[w] = mode_q[w][s_idx];
        assign u_tags[w]  = tag_q[w][u_idx];
        assign u_sts[w]   = st_q[w][u_idx];
        assign u_modes[w] = mode_q[w][u_idx];
    end

    logic [WAYS-1:0] s_occ, u_occ;
    logic            s_any, s_way, u_any, u_way;

    btb_way_match #(.TAG_W(TAG_W)) u_smatch (
        .set_tags(s_tags), .set_states(s_sts), .set_modes(s_modes),
        .way_off(way_off), .want_tag(s_tag), .want_mode(smode_q),
        .occupied(s_occ), .any(s_any), .way(s_way)
    );

    btb_way_match #(.TAG_W(TAG_W)) u_umatch (
        .set_tags(u_tags), .set_states(u_sts), .set_modes(u_modes),
        .way_off(way_off), .want_tag(u_tag), .want_mode(upd_mode),
        .occupied(u_occ), .any(u_any), .way(u_way)
    );

    // update path
    logic upd_go, collide;
    logic modify, load_tgt, want_install, vic_ok, victim, tgt_same;
    bst_e nxt_st;

    assign upd_go   = upd_valid && en && !rcv_clear;
    assign collide  = upd_go && (u_idx == s_idx);
    assign tgt_same = (tgt_q[u_way][u_idx] == upd_target[TGT_W-1:0]);

    btb_resolve u_resolve (
        .found(u_any), .cur(st_q[u_way][u_idx]), .taken(upd_taken),
        .tgt_same(tgt_same), .modify(modify), .nxt(nxt_st),
        .load_tgt(load_tgt), .want_install(want_install)
    );

    btb_victim u_victim (
        .occupied(u_occ), .way_off(way_off), .lru(lru_q[u_idx]),
        .ok(vic_ok), .victim(victim)
    );

    // search decision for the chunk under lookup
    logic s_hit, s_at_end, scanning;
    assign scanning = (state_q == FS_SCAN);
    assign s_hit    = scanning && en && !rcv_clear && !collide && s_any;
    assign s_at_end = (chunk_q == last_q);
    assign busy     = scanning;

    // next-state logic
    always_comb begin
        state_d = state_q;
        chunk_d = chunk_q;
        last_d  = last_q;
        smode_d = smode_q;
        unique case (state_q)
            FS_IDLE: ;
            FS_SCAN: begin
                if (s_hit || s_at_end) state_d = FS_IDLE;
                else                   chunk_d = chunk_q + 1'b1;
            end
        endcase
        if (srch_start) begin
            state_d = FS_SCAN;
            chunk_d = start_chunk;
            last_d  = {start_chunk[CW-1:LINE_CH] + 1'b1, {LINE_CH{1'b1}}};
            smode_d = srch_mode;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            chunk_q <= '0;
            last_q  <= '0;
            smode_q <= 1'b0;
        end else begin
            state_q <= state_d;
            chunk_q <= chunk_d;
            last_q  <= last_d;
            smode_q <= smode_d;
        end
    end

    // result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_chg     <= 1'b0;
            res_target  <= '0;
            res_br_addr <= '0;
        end else begin
            res_valid   <= scanning && (s_hit || s_at_end);
            res_hit     <= s_hit;
            res_chg     <= s_hit && (st_q[s_way][s_idx] == BS_MOVING);
            res_target  <= s_hit ? {chunk_q[CW-1:TGT_W-OFF_W], tgt_q[s_way][s_idx]} : '0;
            res_br_addr <= s_hit ? {chunk_q, {OFF_W{1'b0}}} : '0;
        end
    end

    // entry storage writes
    always_ff @(posedge clk) begin
        if (!rst_n || rcv_clear) begin
            for (int i = 0; i < SETS; i++) begin
                lru_q[i] <= 1'b0;
                for (int w = 0; w < WAYS; w++) st_q[w][i] <= BS_EMPTY;
            end
        end else begin
            if (s_hit) lru_q[s_idx] <= !s_way;
            if (upd_go && modify) begin
                st_q[u_way][u_idx] <= nxt_st;
                if (load_tgt) tgt_q[u_way][u_idx] <= upd_target[TGT_W-1:0];
            end
            if (upd_go && want_install && vic_ok) begin
                tag_q[victim][u_idx]  <= u_tag;
                tgt_q[victim][u_idx]  <= upd_target[TGT_W-1:0];
                mode_q[victim][u_idx] <= upd_mode;
                st_q[victim][u_idx]   <= BS_STRONG;
                lru_q[u_idx]          <= !victim;
            end
        end
    end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int AW    = 32,
    parameter int TGT_W = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          rcv_clear,
    input logic          srch_start,
    input logic          busy,
    input logic          res_valid,
    input logic          res_hit,
    input logic [AW-1:0] res_target,
    input logic [AW-1:0] res_br_addr
);
    a_r7_result_needs_scan: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(busy));

    a_r7_idle_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(srch_start)) |-> !busy);

    a_r2_target_upper: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_target[AW-1:TGT_W] == res_br_addr[AW-1:TGT_W]));

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(en)) |-> !res_hit);

    a_r11_clear_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(rcv_clear)) |-> !res_hit);

    a_r13_hit_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);
endmodule

bind btb_predictor btb_predictor_chk #(.AW(AW), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
    localparam int SETS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1, rcv_clear = 1'b0;
    logic [1:0]  way_off = 2'b00;
    logic        srch_start = 1'b0, srch_mode = 1'b0;
    logic [31:0] srch_addr = '0;
    logic        busy, res_valid, res_hit, res_chg;
    logic [31:0] res_target, res_br_addr;
    logic        upd_valid = 1'b0, upd_mode = 1'b0, upd_taken = 1'b0;
    logic [31:0] upd_addr = '0, upd_target = '0;

    int nvec = 0, nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    btb_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .rcv_clear(rcv_clear), .way_off(way_off),
        .srch_start(srch_start), .srch_addr(srch_addr), .srch_mode(srch_mode),
        .busy(busy), .res_valid(res_valid), .res_hit(res_hit), .res_target(res_target),
        .res_chg(res_chg), .res_br_addr(res_br_addr), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_mode(upd_mode), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    // ---------------- behavioural reference ----------------
    bit [12:0] m_tag  [2][SETS];
    bit [18:0] m_tgt  [2][SETS];
    bit        m_mode [2][SETS];
    bit [1:0]  m_st   [2][SETS];
    bit        m_lru  [SETS];
    bit        m_busy, m_mmode, m_rv, m_rh, m_rc;
    bit [27:0] m_chunk, m_last;
    bit [31:0] m_rt, m_rb;

    task automatic m_wipe();
        for (int i = 0; i < SETS; i++) begin
            m_lru[i] = 0;
            for (int w = 0; w < 2; w++) m_st[w][i] = 0;
        end
    endtask

    task automatic model_step();
        int sidx, uidx, hw, fw, vw;
        bit [12:0] stag, utag;
        bit uacc;
        if (!rst_n) begin
            m_wipe();
            m_busy = 0; m_rv = 0; m_rh = 0; m_rc = 0; m_rt = 0; m_rb = 0;
            return;
        end
        uacc = upd_valid && en && !rcv_clear;
        sidx = int'(m_chunk[9:0]);
        stag = m_chunk[22:10];
        uidx = int'(upd_addr[13:4]);
        utag = upd_addr[26:14];
        m_rv = 0; m_rh = 0; m_rc = 0; m_rt = 0; m_rb = 0;
        if (m_busy) begin
            hw = -1;
            if (en && !rcv_clear && !(uacc && uidx == sidx))
                for (int w = 1; w >= 0; w--)
                    if (m_st[w][sidx] != 0 && !way_off[w] && m_tag[w][sidx] == stag
                        && m_mode[w][sidx] == m_mmode) hw = w;
            if (hw >= 0) begin
                m_rv = 1; m_rh = 1;
                m_rb = {m_chunk, 4'h0};
                m_rt = {m_rb[31:19], m_tgt[hw][sidx]};
                m_rc = (m_st[hw][sidx] == 2'b11);
                m_lru[sidx] = (hw == 0);
                m_busy = 0;
            end else if (m_chunk == m_last) begin
                m_rv = 1; m_busy = 0;
            end else m_chunk = m_chunk + 1;
        end
        if (rcv_clear) m_wipe();
        else if (uacc) begin
            fw = -1;
            for (int w = 1; w >= 0; w--)
                if (m_st[w][uidx] != 0 && !way_off[w] && m_tag[w][uidx] == utag
                    && m_mode[w][uidx] == upd_mode) fw = w;
            if (fw >= 0) begin
                if (upd_taken) begin
                    if (m_tgt[fw][uidx] == upd_target[18:0]) m_st[fw][uidx] = 2'b10;
                    else begin m_tgt[fw][uidx] = upd_target[18:0]; m_st[fw][uidx] = 2'b11; end
                end else begin
                    m_st[fw][uidx] = (m_st[fw][uidx] == 2'b01) ? 2'b00 : 2'b01;
                end
            end else if (upd_taken && way_off != 2'b11) begin
                if (way_off[0]) vw = 1;
                else if (way_off[1]) vw = 0;
                else if (m_st[0][uidx] == 0) vw = 0;
                else if (m_st[1][uidx] == 0) vw = 1;
                else vw = int'(m_lru[uidx]);
                m_tag[vw][uidx] = utag; m_tgt[vw][uidx] = upd_target[18:0];
                m_mode[vw][uidx] = upd_mode; m_st[vw][uidx] = 2'b10;
                m_lru[uidx] = (vw == 0);
            end
        end
        if (srch_start) begin
            m_busy = 1; m_mmode = srch_mode;
            m_chunk = srch_addr[31:4];
            m_last = {srch_addr[31:8] + 24'd1, 4'hF};
        end
    endtask

    always @(posedge clk) model_step();

    // ---------------- checking ----------------
    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison with the reference (R7 timing, R1/R2/R4 content)
    always @(negedge clk) if (rst_n && !done) begin
        check(busy == m_busy, "R7 busy", 32'(busy), 32'(m_busy));
        check(res_valid == m_rv, "R7 res_valid", 32'(res_valid), 32'(m_rv));
        check(res_hit == m_rh, "R1 res_hit", 32'(res_hit), 32'(m_rh));
        if (m_rh) begin
            check(res_br_addr == m_rb, "R1 res_br_addr", res_br_addr, m_rb);
            check(res_target == m_rt, "R2 res_target", res_target, m_rt);
            check(res_chg == m_rc, "R4 res_chg", 32'(res_chg), 32'(m_rc));
        end
    end

    task automatic upd(logic [31:0] a, bit md, bit tk, logic [31:0] t);
        upd_valid = 1; upd_addr = a; upd_mode = md; upd_taken = tk; upd_target = t;
        @(negedge clk);
        upd_valid = 0;
    endtask

    function automatic logic [31:0] pred(logic [31:0] br, logic [31:0] t);
        return {br[31:19], t[18:0]};
    endfunction

    task automatic search(logic [31:0] a, bit md, bit eh, logic [31:0] ebr,
                          logic [31:0] et, bit ec, string req);
        srch_start = 1; srch_addr = a; srch_mode = md;
        @(negedge clk);
        srch_start = 0;
        for (int k = 0; k < 40; k++) begin
            if (res_valid) break;
            @(negedge clk);
        end
        check(res_valid, {req, " result strobe"}, 32'(res_valid), 32'd1);
        check(res_hit == eh, {req, " hit"}, 32'(res_hit), 32'(eh));
        if (eh) begin
            check(res_br_addr == ebr, {req, " branch addr"}, res_br_addr, ebr);
            check(res_target == et, {req, " target"}, res_target, et);
            check(res_chg == ec, {req, " chg"}, 32'(res_chg), 32'(ec));
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [31:0] A   = 32'h5234_5672;
    localparam logic [31:0] AB  = 32'h5234_5670;
    localparam logic [31:0] TA  = 32'h0ABC_DEF4;
    localparam logic [31:0] TB2 = 32'h0001_2348;
    localparam logic [31:0] L   = 32'h3000_8000;
    localparam logic [31:0] P   = 32'h4000_0500;
    localparam logic [31:0] U   = 32'h4000_0A00;

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check(busy == 0, "R13 busy after reset", 32'(busy), 0);
        check(res_valid == 0, "R13 res_valid after reset", 32'(res_valid), 0);
        rst_n = 1;
        @(negedge clk);
        search(A & ~32'hFF, 0, 0, 0, 0, 0, "R13 empty array");

        // R1 not-taken never installs; taken installs
        upd(32'h6000_0300, 0, 0, 32'h1111_1110);
        search(32'h6000_0300, 0, 0, 0, 0, 0, "R1 not-taken absent");
        upd(A, 0, 1, TA);
        search(A & ~32'hFF, 0, 1, AB, pred(AB, TA), 0, "R2 install and pad");

        // R3 confidence ladder
        upd(A, 0, 0, TA);
        search(A & ~32'hFF, 0, 1, AB, pred(AB, TA), 0, "R3 weak still hits");
        upd(A, 0, 1, TA);
        upd(A, 0, 0, TA);
        search(AB, 0, 1, AB, pred(AB, TA), 0, "R3 back to strong then weak");
        upd(A, 0, 0, TA);
        search(AB, 0, 0, 0, 0, 0, "R3 weak evicted");

        // R4 changing target
        upd(A, 0, 1, TA);
        upd(A, 0, 1, TB2);
        search(AB, 0, 1, AB, pred(AB, TB2), 1, "R4 moving flag");
        upd(A, 0, 1, TB2);
        search(AB, 0, 1, AB, pred(AB, TB2), 0, "R4 moving to strong");
        upd(A, 0, 1, TA);
        upd(A, 0, 0, TA);
        search(AB, 0, 1, AB, pred(AB, TA), 0, "R4 moving not-taken to weak");
        upd(A, 0, 1, TA);

        // R5 code class
        search(AB, 1, 0, 0, 0, 0, "R5 class mismatch");
        upd(A, 1, 1, TB2);
        search(AB, 1, 1, AB, pred(AB, TB2), 0, "R5 internal class");
        search(AB, 0, 1, AB, pred(AB, TA), 0, "R5 normal class");

        // R7 window and order
        upd(L + 32'h10, 0, 1, 32'h0000_0A00);
        upd(L + 32'h1F0, 0, 1, 32'h0000_0B00);
        upd(L + 32'h200, 0, 1, 32'h0000_0C00);
        search(L + 32'h20, 0, 1, L + 32'h1F0, pred(L, 32'h0B00), 0, "R7 last chunk of next line");
        search(L, 0, 1, L + 32'h10, pred(L, 32'h0A00), 0, "R7 first in order");
        search(L + 32'h110, 0, 1, L + 32'h1F0, pred(L, 32'h0B00), 0, "R7 nearer branch wins");
        search(L + 32'h210, 0, 0, 0, 0, 0, "R7 behind start is skipped");

        // R8 restart while busy
        srch_start = 1; srch_addr = 32'h7000_0000; srch_mode = 0;
        @(negedge clk);
        srch_addr = L;
        @(negedge clk);
        srch_start = 0;
        for (int k = 0; k < 40; k++) begin
            if (res_valid) break;
            @(negedge clk);
        end
        check(res_hit && res_br_addr == L + 32'h10, "R8 restart finds new window",
              res_br_addr, L + 32'h10);
        @(negedge clk);

        // R10 collision: update same set in the lookup cycle of that chunk
        srch_start = 1; srch_addr = AB; srch_mode = 0;
        @(negedge clk);
        srch_start = 0;
        upd(A ^ 32'h0010_0000, 0, 0, 0);
        for (int k = 0; k < 40; k++) begin
            if (res_valid) break;
            @(negedge clk);
        end
        check(res_valid && !res_hit, "R10 collision misses", 32'(res_hit), 0);
        @(negedge clk);
        search(AB, 0, 1, AB, pred(AB, TA), 0, "R10 entry intact");

        // R6 replacement and no duplicate
        upd(P, 0, 1, 32'h0000_1000);
        upd(P + 32'h4000, 0, 1, 32'h0000_2000);
        search(P, 0, 1, P, pred(P, 32'h1000), 0, "R6 first way hit");
        upd(P + 32'h8000, 0, 1, 32'h0000_3000);
        search(P + 32'h4000, 0, 0, 0, 0, 0, "R6 replaced way misses");
        search(P + 32'h8000, 0, 1, P + 32'h8000, pred(P, 32'h3000), 0, "R6 new branch hits");
        upd(P, 0, 1, 32'h0000_1000);
        upd(P, 0, 0, 0);
        upd(P, 0, 0, 0);
        search(P, 0, 0, 0, 0, 0, "R6 no duplicate copy");
        search(P + 32'h8000, 0, 1, P + 32'h8000, pred(P, 32'h3000), 0, "R6 other way kept");

        // R12 way exclusion
        upd(U, 0, 1, 32'h0000_4000);
        upd(U + 32'h4000, 0, 1, 32'h0000_5000);
        way_off = 2'b01;
        search(U, 0, 0, 0, 0, 0, "R12 excluded way misses");
        search(U + 32'h4000, 0, 1, U + 32'h4000, pred(U, 32'h5000), 0, "R12 live way hits");
        upd(U + 32'h8000, 0, 1, 32'h0000_6000);
        way_off = 2'b00;
        search(U, 0, 1, U, pred(U, 32'h4000), 0, "R12 excluded way untouched");
        search(U + 32'h4000, 0, 0, 0, 0, 0, "R12 install into live way");
        search(U + 32'h8000, 0, 1, U + 32'h8000, pred(U, 32'h6000), 0, "R12 installed branch");

        // R9 global enable
        en = 0;
        search(AB, 0, 0, 0, 0, 0, "R9 disabled lookup");
        upd(32'h6100_0040, 0, 1, 32'h0000_7000);
        upd(A, 0, 0, TA);
        upd(A, 0, 0, TA);
        en = 1;
        search(32'h6100_0040, 0, 0, 0, 0, 0, "R9 disabled install");
        search(AB, 0, 1, AB, pred(AB, TA), 0, "R9 disabled update ignored");

        // R11 recovery clear
        rcv_clear = 1;
        @(negedge clk);
        rcv_clear = 0;
        search(AB, 0, 0, 0, 0, 0, "R11 cleared");
        search(L, 0, 0, 0, 0, 0, "R11 cleared window");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule